// File: doc/BRIEF.md
# Wake and Fault Blanking Gate

This block sits between the register-write path and the transmit engine of a low-frequency transmitter. It runs on the internal clock, which may be gated. It watches three kinds of traffic: configuration writes, command requests and status reads.

- **Configuration writes.** A written configuration goes into a pending slot. It becomes the active configuration only after a fixed settling delay.
- **Wake command.** A configuration write whose sleep bit is zero opens a fault blanking window. The window covers the settling delay plus a further stretch.
- **Status read that clears faults.** A status read that finds latched faults clears them and opens a blanking window of its own.

While any window is open, fault inputs are masked and nothing new is latched. While a window opened by a wake command is open, some commands are refused:

- a start-transmission request is always refused;
- a write to the first data buffer is refused when the most recently written sending mode is autosend.

Refused requests are dropped, so they never reach the transmit engine, and they set a sticky flag. Accepted requests pass straight through in the same cycle. A busy output covers the whole stretch from a configuration write until both the settling delay and any blanking window have run out.

Top module: `wake_blank_gate`

## Requirements
- R1: While reset is asserted the outputs are as follows:
  - `sleep_o` is 1;
  - `autosend_o`, `fault_o`, `rejected_o`, `blanking_o` and `busy_o` are all 0.
- R2: A configuration write sampled at clock edge k drives `sleep_o`/`autosend_o` to the written values at edge k+SETTLE_CYC (default 4). A further write before that edge restarts the delay and replaces the pending values. Without a write in progress, the active configuration never changes.
- R3: A configuration write with `cfg_sleep_i`=0 is a wake command. From the following cycle `blanking_o` is high for SETTLE_CYC+WAKE_EXTRA cycles (default 128). A write with `cfg_sleep_i`=1 opens no window.
- R4: While a window opened by a wake command is running, `start_tx_o` is held low whatever the sending mode. At all other times `start_tx_o` equals `start_tx_i` in the same cycle.
- R5: While a wake-opened window is running, `buf1_wr_o` is held low if the autosend bit of the most recent configuration write is 1. At all other times `buf1_wr_o` equals `buf1_wr_i` in the same cycle.
- R6: A status read while any `fault_o` bit is 1 clears every bit and opens a blanking window of CLR_TOTAL cycles (default 128) from the next cycle. This window alone refuses no command. A status read with no latched fault opens no window.
- R7: Each `fault_i` bit that is high in a cycle with `blanking_o` low sets the same bit of `fault_o` from the next cycle, and the bit stays set until it is cleared (R6). Fault inputs seen while `blanking_o` is high have no effect on `fault_o`.
- R8: A refused request sets `rejected_o` from the next cycle. The flag stays set until a status read in a cycle with no refusal clears it.
- R9: A blanking event during a running window reloads the counter with the larger of the remaining count and the new window length. A wake refusal period, once started, lasts until the merged window ends.
- R10: `busy_o` is high exactly while the settling delay or a blanking window is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sleep_i | input | 1 | Sleep bit carried by the write (0 = wake) |
| cfg_autosend_i | input | 1 | Sending mode carried by the write (1 = autosend) |
| buf1_wr_i | input | 1 | Request to write the first data buffer |
| start_tx_i | input | 1 | Start-transmission request |
| stat_rd_i | input | 1 | Status register read strobe |
| fault_i | input | NFAULT | Raw fault detector inputs |
| sleep_o | output | 1 | Active sleep bit |
| autosend_o | output | 1 | Active sending mode |
| buf1_wr_o | output | 1 | Accepted buffer write to transmit engine |
| start_tx_o | output | 1 | Accepted start request to transmit engine |
| fault_o | output | NFAULT | Latched faults |
| rejected_o | output | 1 | Sticky refused-request flag |
| blanking_o | output | 1 | A blanking window is running |
| busy_o | output | 1 | Settling or blanking still in progress |

## Verification
The hardest situation to reach is a fault-clear read landing inside a running wake window. Faults are masked for the whole wake window, so no new fault can be latched then. To get there, the stimulus first latches a fault while the block is idle and then issues the wake command. It next waits 60 cycles into the window and reads status. The total length of blanking and the continued refusal of start requests are then measured against the merged end point. A long stretch of random strobes afterwards compares every output each cycle against a behavioural model. That stretch covers the remaining overlaps, such as a write during settling or a refusal on the same cycle as a read.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

    typedef struct packed {
        logic sleep;
        logic autosend;
    } wbg_cfg_t;

    localparam wbg_cfg_t WBG_CFG_RESET = '{sleep: 1'b1, autosend: 1'b0};

endpackage

// File: rtl/wbg_settle.sv
module wbg_settle
    import wbg_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  wbg_cfg_t cfg_i,
    output logic     pend_auto_o,
    output wbg_cfg_t act_o,
    output logic     settling_o
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LOAD = SW'(SETTLE_CYC);
    localparam logic [SW-1:0] ONE  = SW'(1);

    typedef struct packed {
        logic [SW-1:0] cnt;
        wbg_cfg_t      pend;
        wbg_cfg_t      act;
    } settle_st_t;

    settle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.pend = cfg_i;
            st_d.cnt  = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) begin
                st_d.act = st_q.pend;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, pend: WBG_CFG_RESET, act: WBG_CFG_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_auto_o = st_q.pend.autosend;
    assign act_o       = st_q.act;
    assign settling_o  = (st_q.cnt != '0);

endmodule

// File: rtl/wbg_window.sv
module wbg_window #(
    parameter int WAKE_LEN = 128,
    parameter int CLR_LEN  = 128,
    parameter int CW       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_ev_i,
    input  logic clr_ev_i,
    output logic blanking_o,
    output logic wake_win_o
);

    localparam logic [CW-1:0] WAKE_L = CW'(WAKE_LEN);
    localparam logic [CW-1:0] CLR_L  = CW'(CLR_LEN);
    localparam logic [CW-1:0] ONE    = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wake;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [CW-1:0] dec;
    logic [CW-1:0] req;

    always_comb begin
        st_d = st_q;
        dec  = (st_q.cnt != '0) ? (st_q.cnt - ONE) : '0;
        req  = '0;
        if (wake_ev_i) begin
            req = WAKE_L;
        end
        if (clr_ev_i && (CLR_L > req)) begin
            req = CLR_L;
        end
        st_d.cnt = (req > dec) ? req : dec;
        if (wake_ev_i) begin
            st_d.wake = 1'b1;
        end else if (st_d.cnt == '0) begin
            st_d.wake = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blanking_o = (st_q.cnt != '0);
    assign wake_win_o = st_q.wake && (st_q.cnt != '0);

endmodule

// File: rtl/wbg_fault.sv
module wbg_fault #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] fault_i,
    input  logic          blanking_i,
    input  logic          rd_i,
    output logic [NF-1:0] latched_o,
    output logic          clr_ev_o
);

    typedef struct packed {
        logic [NF-1:0] flt;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    clr;

    always_comb begin
        st_d = st_q;
        clr  = rd_i && (st_q.flt != '0);
        if (clr) begin
            st_d.flt = '0;
        end else if (!blanking_i) begin
            st_d.flt = st_q.flt | fault_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latched_o = st_q.flt;
    assign clr_ev_o  = clr;

endmodule

// File: rtl/wbg_gate.sv
module wbg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic buf_i,
    input  logic wake_win_i,
    input  logic autosend_i,
    input  logic rd_i,
    output logic start_o,
    output logic buf_o,
    output logic rejected_o
);

    typedef struct packed {
        logic rej;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     block_start;
    logic     block_buf;
    logic     refuse;

    always_comb begin
        st_d        = st_q;
        block_start = wake_win_i;
        block_buf   = wake_win_i && autosend_i;
        refuse      = (start_i && block_start) || (buf_i && block_buf);
        if (refuse) begin
            st_d.rej = 1'b1;
        end else if (rd_i) begin
            st_d.rej = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o    = start_i && !block_start;
    assign buf_o      = buf_i && !block_buf;
    assign rejected_o = st_q.rej;

endmodule

// File: rtl/wake_blank_gate.sv
module wake_blank_gate
    import wbg_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int WAKE_EXTRA = 124,
    parameter int CLR_TOTAL  = 128,
    parameter int NFAULT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              cfg_sleep_i,
    input  logic              cfg_autosend_i,
    input  logic              buf1_wr_i,
    input  logic              start_tx_i,
    input  logic              stat_rd_i,
    input  logic [NFAULT-1:0] fault_i,
    output logic              sleep_o,
    output logic              autosend_o,
    output logic              buf1_wr_o,
    output logic              start_tx_o,
    output logic [NFAULT-1:0] fault_o,
    output logic              rejected_o,
    output logic              blanking_o,
    output logic              busy_o
);

    localparam int WAKE_LEN = SETTLE_CYC + WAKE_EXTRA;
    localparam int MAX_LEN  = (WAKE_LEN > CLR_TOTAL) ? WAKE_LEN : CLR_TOTAL;
    localparam int CW       = $clog2(MAX_LEN + 1);

    wbg_cfg_t wr_cfg;
    wbg_cfg_t act_cfg;
    logic     pend_auto;
    logic     settling;
    logic     wake_ev;
    logic     clr_ev;
    logic     wake_win;
    logic     blanking;

    assign wr_cfg  = '{sleep: cfg_sleep_i, autosend: cfg_autosend_i};
    assign wake_ev = cfg_wr_i && !cfg_sleep_i;

    wbg_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .cfg_i      (wr_cfg),
        .pend_auto_o(pend_auto),
        .act_o      (act_cfg),
        .settling_o (settling)
    );

    wbg_window #(.WAKE_LEN(WAKE_LEN), .CLR_LEN(CLR_TOTAL), .CW(CW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_ev_i (wake_ev),
        .clr_ev_i  (clr_ev),
        .blanking_o(blanking),
        .wake_win_o(wake_win)
    );

    wbg_fault #(.NF(NFAULT)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_i   (fault_i),
        .blanking_i(blanking),
        .rd_i      (stat_rd_i),
        .latched_o (fault_o),
        .clr_ev_o  (clr_ev)
    );

    wbg_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_tx_i),
        .buf_i     (buf1_wr_i),
        .wake_win_i(wake_win),
        .autosend_i(pend_auto),
        .rd_i      (stat_rd_i),
        .start_o   (start_tx_o),
        .buf_o     (buf1_wr_o),
        .rejected_o(rejected_o)
    );

    assign sleep_o    = act_cfg.sleep;
    assign autosend_o = act_cfg.autosend;
    assign blanking_o = blanking;
    assign busy_o     = settling || blanking;

endmodule

// File: rtl/wake_blank_gate_chk.sv
module wake_blank_gate_chk #(
    parameter int NFAULT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic              cfg_sleep_i,
    input logic              start_tx_i,
    input logic              stat_rd_i,
    input logic              sleep_o,
    input logic              autosend_o,
    input logic              buf1_wr_o,
    input logic              start_tx_o,
    input logic [NFAULT-1:0] fault_o,
    input logic              rejected_o,
    input logic              blanking_o,
    input logic              busy_o,
    input logic              wake_win,
    input logic              pend_auto
);

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(sleep_o) && $stable(autosend_o)));

    p_wake_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !cfg_sleep_i) |=> (blanking_o && busy_o));

    p_start_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_win |-> !start_tx_o);

    p_buf_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_win && pend_auto) |-> !buf1_wr_o);

    p_clear_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && (fault_o != '0)) |=> (blanking_o && (fault_o == '0)));

    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking_o && !stat_rd_i) |=> $stable(fault_o));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rejected_o && !stat_rd_i) |=> rejected_o);

    p_refuse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx_i && !start_tx_o) |=> rejected_o);

    p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blanking_o |-> busy_o);

endmodule

bind wake_blank_gate wake_blank_gate_chk #(.NFAULT(NFAULT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_sleep_i(cfg_sleep_i),
    .start_tx_i (start_tx_i),
    .stat_rd_i  (stat_rd_i),
    .sleep_o    (sleep_o),
    .autosend_o (autosend_o),
    .buf1_wr_o  (buf1_wr_o),
    .start_tx_o (start_tx_o),
    .fault_o    (fault_o),
    .rejected_o (rejected_o),
    .blanking_o (blanking_o),
    .busy_o     (busy_o),
    .wake_win   (wake_win),
    .pend_auto  (pend_auto)
);

// File: tb/wake_blank_gate_tb.sv
module wake_blank_gate_tb;

    localparam int NF     = 4;
    localparam int SETTLE = 4;
    localparam int WAKE_T = 128;
    localparam int CLR_T  = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_i, cfg_sleep_i, cfg_autosend_i;
    logic          buf1_wr_i, start_tx_i, stat_rd_i;
    logic [NF-1:0] fault_i;
    logic          sleep_o, autosend_o, buf1_wr_o, start_tx_o;
    logic [NF-1:0] fault_o;
    logic          rejected_o, blanking_o, busy_o;

    always #4 clk = ~clk;

    wake_blank_gate #(.NFAULT(NF)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr_i), .cfg_sleep_i(cfg_sleep_i), .cfg_autosend_i(cfg_autosend_i),
        .buf1_wr_i(buf1_wr_i), .start_tx_i(start_tx_i), .stat_rd_i(stat_rd_i),
        .fault_i(fault_i),
        .sleep_o(sleep_o), .autosend_o(autosend_o), .buf1_wr_o(buf1_wr_o),
        .start_tx_o(start_tx_o), .fault_o(fault_o), .rejected_o(rejected_o),
        .blanking_o(blanking_o), .busy_o(busy_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    int          m_settle, m_win;
    bit          m_wake, m_psleep, m_pauto, m_sleep, m_auto, m_rej;
    bit [NF-1:0] m_flt;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_settle = 0; m_win = 0; m_wake = 0;
        m_psleep = 1; m_pauto = 0; m_sleep = 1; m_auto = 0;
        m_rej = 0; m_flt = '0;
    endtask

    task automatic strobes_off();
        cfg_wr_i = 0; cfg_sleep_i = 1; cfg_autosend_i = 0;
        buf1_wr_i = 0; start_tx_i = 0; stat_rd_i = 0; fault_i = '0;
    endtask

    // inputs are applied at a falling edge; compare, advance model, wait next falling edge
    task automatic tick();
        bit inw, refuse, wake_ev, clr_ev;
        int dec, req, nwin;
        #1;
        inw = m_wake && (m_win > 0);
        chk("R4", "start_tx_o", start_tx_o, start_tx_i && !inw);
        chk("R5", "buf1_wr_o", buf1_wr_o, buf1_wr_i && !(inw && m_pauto));
        chk("R2", "sleep_o", sleep_o, m_sleep);
        chk("R2", "autosend_o", autosend_o, m_auto);
        chk("R3", "blanking_o", blanking_o, m_win > 0);
        chk("R7", "fault_o", fault_o, m_flt);
        chk("R8", "rejected_o", rejected_o, m_rej);
        chk("R10", "busy_o", busy_o, (m_settle > 0) || (m_win > 0));
        refuse  = (start_tx_i && inw) || (buf1_wr_i && inw && m_pauto);
        wake_ev = cfg_wr_i && !cfg_sleep_i;
        clr_ev  = stat_rd_i && (m_flt != 0);
        dec  = (m_win > 0) ? m_win - 1 : 0;
        req  = 0;
        if (wake_ev) req = WAKE_T;
        if (clr_ev && CLR_T > req) req = CLR_T;
        nwin = (req > dec) ? req : dec;
        if (wake_ev) m_wake = 1; else if (nwin == 0) m_wake = 0;
        if (clr_ev) m_flt = '0;
        else if (m_win == 0) m_flt = m_flt | fault_i;
        m_win = nwin;
        if (refuse) m_rej = 1; else if (stat_rd_i) m_rej = 0;
        if (cfg_wr_i) begin
            m_psleep = cfg_sleep_i; m_pauto = cfg_autosend_i; m_settle = SETTLE;
        end else if (m_settle > 0) begin
            if (m_settle == 1) begin m_sleep = m_psleep; m_auto = m_pauto; end
            m_settle--;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        strobes_off();
        repeat (n) tick();
    endtask

    task automatic cfg(bit slp, bit aut);
        strobes_off();
        cfg_wr_i = 1; cfg_sleep_i = slp; cfg_autosend_i = aut;
        tick();
        strobes_off();
    endtask

    task automatic rd();
        strobes_off();
        stat_rd_i = 1;
        tick();
        strobes_off();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cnt;
        rst_n = 0;
        strobes_off();
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "sleep_o", sleep_o, 1);
        chk("R1", "autosend_o", autosend_o, 0);
        chk("R1", "fault_o", fault_o, 0);
        chk("R1", "rejected_o", rejected_o, 0);
        chk("R1", "blanking_o", blanking_o, 0);
        chk("R1", "busy_o", busy_o, 0);
        @(negedge clk);
        rst_n = 1;
        idle(3);

        // R2 non-wake write applies after the settling delay, no window (R3)
        cfg(1, 1);
        cnt = 0;
        while (!autosend_o && cnt < 20) begin tick(); cnt++; end
        chk("R2", "cycles to apply", cnt, SETTLE);
        chk("R3", "no window on sleep write", blanking_o, 0);
        idle(2);

        // R2 restart: second write replaces pending value before it applies
        cfg(1, 0);
        idle(2);
        cfg(1, 1);
        cnt = 0;
        repeat (10) begin if (!autosend_o) cnt++; tick(); end
        chk("R2", "restart kept autosend", cnt, 0);

        // R7 latch faults outside blanking; R4 start passes when idle
        strobes_off(); fault_i = 4'b0101; tick();
        strobes_off(); start_tx_i = 1; #1;
        chk("R4", "start passes idle", start_tx_o, 1);
        tick();
        strobes_off();
        chk("R7", "latched", fault_o, 4'b0101);

        // wake with autosend: refusals, then fault clear inside the window (R9)
        cfg(0, 1);
        cnt = 0;
        strobes_off(); buf1_wr_i = 1; fault_i = 4'b1010; #1;
        chk("R5", "buf refused autosend", buf1_wr_o, 0);
        if (blanking_o) cnt++;
        tick();
        chk("R8", "rejected set", rejected_o, 1);
        chk("R7", "masked fault ignored", fault_o, 4'b0101);
        strobes_off();
        repeat (59) begin if (blanking_o) cnt++; tick(); end
        if (blanking_o) cnt++;
        rd();
        chk("R6", "cleared in wake window", fault_o, 0);
        chk("R8", "rejected cleared by read", rejected_o, 0);
        strobes_off(); start_tx_i = 1; #1;
        chk("R9", "wake refusal persists", start_tx_o, 0);
        if (blanking_o) cnt++;
        tick();
        strobes_off();
        while (blanking_o && cnt < 1000) begin cnt++; tick(); end
        chk("R9", "merged window length", cnt, 61 + CLR_T);

        // R6 read with nothing latched opens no window
        rd();
        chk("R6", "no window without fault", blanking_o, 0);

        // R6 fault-clear window alone: commands pass
        strobes_off(); fault_i = 4'b0010; tick();
        rd();
        cnt = 0;
        strobes_off(); start_tx_i = 1; buf1_wr_i = 1; #1;
        chk("R6", "start passes in clear window", start_tx_o, 1);
        chk("R6", "buf passes in clear window", buf1_wr_o, 1);
        while (blanking_o && cnt < 1000) begin cnt++; tick(); end
        chk("R6", "clear window length", cnt, CLR_T);
        strobes_off();
        rd();

        // R5 wake without autosend: buffer passes, start refused
        cfg(0, 0);
        strobes_off(); buf1_wr_i = 1; start_tx_i = 1; #1;
        chk("R5", "buf passes normal mode", buf1_wr_o, 1);
        chk("R4", "start refused normal mode", start_tx_o, 0);
        tick();
        strobes_off();
        cnt = 1;
        while (blanking_o && cnt < 1000) begin cnt++; tick(); end
        chk("R3", "wake window length", cnt, WAKE_T);

        // random stretch compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            strobes_off();
            cfg_wr_i       = ($urandom_range(0, 149) == 0);
            cfg_sleep_i    = $urandom_range(0, 1);
            cfg_autosend_i = $urandom_range(0, 1);
            buf1_wr_i      = ($urandom_range(0, 7) == 0);
            start_tx_i     = ($urandom_range(0, 7) == 0);
            stat_rd_i      = ($urandom_range(0, 39) == 0);
            fault_i        = ($urandom_range(0, 29) == 0) ? NF'($urandom) : '0;
            tick();
        end
        idle(5);
        summary();
    end

endmodule